// File: doc/BRIEF.md
# Value-Matching Watchpoint Unit

This block watches the memory traffic and the instruction fetch stream of a core and raises a trap request when a configured slot matches. Each slot can be disabled, or can compare against one of three operands: the address of a data access, the data value carried by a load or store, or the physical program counter of an instruction fetch. Because fetch slots compare physical addresses, a breakpoint hits no matter which virtual address the calling code used.

A match does not go to a debugger. It asks the core to enter its privileged hidden execution mode, where a hidden handler takes control. While the core is already in that mode, all matching is switched off so that the handler cannot trap into itself. Vectoring the exception inside the core lies outside this block.

Slots are loaded through a simple configuration write port: one slot per cycle, taking effect from the next cycle. Each slot holds a mode, a compare value, a per-bit mask and separate enables for loads and stores.

Top module: `watch_trap_unit`

## Requirements
- R1: After reset, trapReq is 0, trapSlot is 0 and every slot is disabled, so no access traps until a slot is configured.
- R2: In address mode (mode code 1), a data access traps when ((accAddr XOR compare) AND mask) is zero and the access kind is enabled for that slot; trapReq rises in the cycle after the access.
- R3: In value mode (mode code 2), a data access traps when ((accData XOR compare) AND mask) is zero, for loads and for stores alike when enabled.
- R4: A load (accIsStore 0) can only hit a slot whose load enable is set, and a store (accIsStore 1) can only hit a slot whose store enable is set; without accValid no address or value slot hits.
- R5: In fetch mode (mode code 3), a slot compares fetchPc, needs fetchValid and ignores both the load/store enables and data accesses; address and value slots ignore fetches.
- R6: Mask bits that are 0 are ignored in the compare; a mask of all zeros matches every operand.
- R7: When several slots hit in the same cycle, trapSlot reports the lowest-numbered one.
- R8: While hiddenMode is 1, no slot hits and trapReq stays 0 in the following cycle.
- R9: trapReq is high for exactly one cycle per matching cycle; trapSlot keeps its last value while trapReq is 0.
- R10: A configuration write (cfgWrEn with cfgSlot) replaces that slot's settings from the next cycle on and leaves the other slots unchanged; mode code 0 disables a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write the slot selected by cfgSlot |
| cfgSlot | input | IDXW | Slot index for the configuration write |
| cfgMode | input | 2 | 0 off, 1 data address, 2 data value, 3 fetch PC |
| cfgCompare | input | WIDTH | Compare value |
| cfgMask | input | WIDTH | Per-bit compare mask, 1 = bit is compared |
| cfgLdEn | input | 1 | Slot may hit on loads |
| cfgStEn | input | 1 | Slot may hit on stores |
| accValid | input | 1 | A data access is present this cycle |
| accIsStore | input | 1 | 1 = store, 0 = load |
| accAddr | input | WIDTH | Data access address |
| accData | input | WIDTH | Load or store data value |
| fetchValid | input | 1 | An instruction fetch is present this cycle |
| fetchPc | input | WIDTH | Physical fetch address |
| hiddenMode | input | 1 | Core already runs in hidden mode |
| trapReq | output | 1 | Request to enter hidden mode, one cycle per match |
| trapSlot | output | IDXW | Lowest slot that hit |

## Verification
The assertions take for granted that accIsStore, accAddr, accData and fetchPc are only meaningful while their valid strobe is high, that hiddenMode is a level from the core which may change on any cycle, and that configuration writes never overlap an access aimed at the same slot in the same cycle. The stimulus keeps to this by driving every input at the falling edge, by writing a slot only in cycles with no access, and by lowering the valid strobes between test phases. Hidden mode is raised and dropped around accesses that would otherwise hit, and data and fetch traffic are mixed in one cycle so that several slots of different modes compete for priority.

// File: rtl/wp_pkg.sv
package wp_pkg;

  // Slot operating mode; the code values are visible on cfgMode.
  typedef enum logic [1:0] {
    WP_OFF   = 2'd0,
    WP_ADDR  = 2'd1,
    WP_VALUE = 2'd2,
    WP_FETCH = 2'd3
  } wp_mode_e;

  // Upper bound on the slot index width carried in the strobe struct.
  localparam int WP_SLOT_BITS_MAX = 4;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic                        wrEn;
    logic [WP_SLOT_BITS_MAX-1:0] wrSlot;
    logic                        matchEn;
  } wp_strobe_t;

endpackage

// File: rtl/wp_datapath.sv
module wp_datapath
  import wp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WIDTH     = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wp_strobe_t           strobe,
  input  wp_mode_e             cfgMode,
  input  logic [WIDTH-1:0]     cfgCompare,
  input  logic [WIDTH-1:0]     cfgMask,
  input  logic                 cfgLdEn,
  input  logic                 cfgStEn,
  input  logic                 accValid,
  input  logic                 accIsStore,
  input  logic [WIDTH-1:0]     accAddr,
  input  logic [WIDTH-1:0]     accData,
  input  logic                 fetchValid,
  input  logic [WIDTH-1:0]     fetchPc,
  output logic [NUM_SLOTS-1:0] hitVec
);

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    wp_mode_e         slotMode;
    logic [WIDTH-1:0] slotCmp;
    logic [WIDTH-1:0] slotMask;
    logic             slotLd;
    logic             slotSt;
    logic [WIDTH-1:0] operand;
    logic             kindOk;
    logic             bitsEqual;
    logic             slotWr;

    assign slotWr = strobe.wrEn && (strobe.wrSlot == WP_SLOT_BITS_MAX'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotMode <= WP_OFF;
        slotCmp  <= '0;
        slotMask <= '0;
        slotLd   <= 1'b0;
        slotSt   <= 1'b0;
      end else if (slotWr) begin
        slotMode <= cfgMode;
        slotCmp  <= cfgCompare;
        slotMask <= cfgMask;
        slotLd   <= cfgLdEn;
        slotSt   <= cfgStEn;
      end
    end

    // One comparator per slot, fed by a mode-selected operand.
    always_comb begin
      operand = fetchPc;
      kindOk  = 1'b0;
      case (slotMode)
        WP_ADDR: begin
          operand = accAddr;
          kindOk  = accValid && (accIsStore ? slotSt : slotLd);
        end
        WP_VALUE: begin
          operand = accData;
          kindOk  = accValid && (accIsStore ? slotSt : slotLd);
        end
        WP_FETCH: begin
          operand = fetchPc;
          kindOk  = fetchValid;
        end
        default: begin
          operand = fetchPc;
          kindOk  = 1'b0;
        end
      endcase
    end

    assign bitsEqual = ((operand ^ slotCmp) & slotMask) == '0;
    assign hitVec[i] = strobe.matchEn && kindOk && bitsEqual;

    // R10
    off_slot_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
      (slotMode == WP_OFF) |-> !hitVec[i]);

    // R5
    fetch_needs_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
      (slotMode == WP_FETCH && !fetchValid) |-> !hitVec[i]);

    // R4
    data_needs_access_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((slotMode == WP_ADDR || slotMode == WP_VALUE) && !accValid) |-> !hitVec[i]);
  end

endmodule

// File: rtl/wp_control.sv
module wp_control
  import wp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDXW      = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic [IDXW-1:0]      cfgSlot,
  input  logic                 hiddenMode,
  input  logic [NUM_SLOTS-1:0] hitVec,
  output wp_strobe_t           strobe,
  output logic                 trapReq,
  output logic [IDXW-1:0]      trapSlot
);

  logic            anyHit;
  logic [IDXW-1:0] firstHit;

  always_comb begin
    strobe.wrEn    = cfgWrEn;
    strobe.wrSlot  = WP_SLOT_BITS_MAX'(cfgSlot);
    strobe.matchEn = !hiddenMode;
  end

  // Lowest index wins: scan downwards so the last assignment is the lowest hit.
  always_comb begin
    anyHit   = 1'b0;
    firstHit = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        anyHit   = 1'b1;
        firstHit = IDXW'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapReq  <= 1'b0;
      trapSlot <= '0;
    end else begin
      trapReq <= anyHit;
      if (anyHit) trapSlot <= firstHit;
    end
  end

  function automatic logic lowestOk(input logic [NUM_SLOTS-1:0] v,
                                    input logic [IDXW-1:0] idx);
    logic [NUM_SLOTS-1:0] below;
    below = (NUM_SLOTS'(1) << idx) - NUM_SLOTS'(1);
    return v[idx] && ((v & below) == '0);
  endfunction

  // R8
  hidden_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiddenMode |=> !trapReq);

  // R2
  hit_then_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> trapReq);

  // R9
  no_hit_no_trap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(|hitVec) |=> !trapReq);

  // R7
  lowest_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> lowestOk($past(hitVec), trapSlot));

  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> $stable(trapSlot));

endmodule

// File: rtl/watch_trap_unit.sv
module watch_trap_unit
  import wp_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int WIDTH     = 32,
  localparam int IDXW     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDXW-1:0]  cfgSlot,
  input  logic [1:0]       cfgMode,
  input  logic [WIDTH-1:0] cfgCompare,
  input  logic [WIDTH-1:0] cfgMask,
  input  logic             cfgLdEn,
  input  logic             cfgStEn,
  input  logic             accValid,
  input  logic             accIsStore,
  input  logic [WIDTH-1:0] accAddr,
  input  logic [WIDTH-1:0] accData,
  input  logic             fetchValid,
  input  logic [WIDTH-1:0] fetchPc,
  input  logic             hiddenMode,
  output logic             trapReq,
  output logic [IDXW-1:0]  trapSlot
);

  wp_strobe_t           strobe;
  logic [NUM_SLOTS-1:0] hitVec;

  wp_control #(.NUM_SLOTS(NUM_SLOTS), .IDXW(IDXW)) u_control (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSlot    (cfgSlot),
    .hiddenMode (hiddenMode),
    .hitVec     (hitVec),
    .strobe     (strobe),
    .trapReq    (trapReq),
    .trapSlot   (trapSlot)
  );

  wp_datapath #(.NUM_SLOTS(NUM_SLOTS), .WIDTH(WIDTH)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgMode    (wp_mode_e'(cfgMode)),
    .cfgCompare (cfgCompare),
    .cfgMask    (cfgMask),
    .cfgLdEn    (cfgLdEn),
    .cfgStEn    (cfgStEn),
    .accValid   (accValid),
    .accIsStore (accIsStore),
    .accAddr    (accAddr),
    .accData    (accData),
    .fetchValid (fetchValid),
    .fetchPc    (fetchPc),
    .hitVec     (hitVec)
  );

endmodule

// File: tb/watch_trap_unit_bench.sv
module watch_trap_unit_bench;

  localparam int N = 4;
  localparam int W = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWrEn = 1'b0;
  logic [1:0]    cfgSlot = '0;
  logic [1:0]    cfgMode = '0;
  logic [W-1:0]  cfgCompare = '0;
  logic [W-1:0]  cfgMask = '0;
  logic          cfgLdEn = 1'b0;
  logic          cfgStEn = 1'b0;
  logic          accValid = 1'b0;
  logic          accIsStore = 1'b0;
  logic [W-1:0]  accAddr = '0;
  logic [W-1:0]  accData = '0;
  logic          fetchValid = 1'b0;
  logic [W-1:0]  fetchPc = '0;
  logic          hiddenMode = 1'b0;
  logic          trapReq;
  logic [1:0]    trapSlot;

  always #10 clk = ~clk;

  watch_trap_unit #(.NUM_SLOTS(N), .WIDTH(W)) u_watch_trap_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSlot(cfgSlot),
    .cfgMode(cfgMode), .cfgCompare(cfgCompare), .cfgMask(cfgMask),
    .cfgLdEn(cfgLdEn), .cfgStEn(cfgStEn), .accValid(accValid),
    .accIsStore(accIsStore), .accAddr(accAddr), .accData(accData),
    .fetchValid(fetchValid), .fetchPc(fetchPc), .hiddenMode(hiddenMode),
    .trapReq(trapReq), .trapSlot(trapSlot)
  );

  typedef struct {
    logic       req;
    logic [1:0] slot;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Reference state, built from the requirements.
  logic [1:0]   mMode [N];
  logic [W-1:0] mCmp  [N];
  logic [W-1:0] mMask [N];
  logic         mLd   [N];
  logic         mSt   [N];
  logic [1:0]   heldSlot = '0;

  function automatic bit refHit(int i, bit av, bit st, logic [W-1:0] a,
                                logic [W-1:0] d, bit fv, logic [W-1:0] pc, bit hid);
    if (hid) return 1'b0;
    case (mMode[i])
      2'd1: return av && (st ? mSt[i] : mLd[i]) && (((a ^ mCmp[i]) & mMask[i]) == '0);
      2'd2: return av && (st ? mSt[i] : mLd[i]) && (((d ^ mCmp[i]) & mMask[i]) == '0);
      2'd3: return fv && (((pc ^ mCmp[i]) & mMask[i]) == '0);
      default: return 1'b0;
    endcase
  endfunction

  task automatic cfg(input int s, input logic [1:0] m, input logic [W-1:0] c,
                     input logic [W-1:0] k, input bit ld, input bit st);
    exp_t e;
    @(negedge clk);
    accValid = 0; fetchValid = 0; hiddenMode = 0;
    cfgWrEn = 1; cfgSlot = 2'(s); cfgMode = m; cfgCompare = c; cfgMask = k;
    cfgLdEn = ld; cfgStEn = st;
    e.req = 0; e.slot = heldSlot; e.tag = "R10";
    q.push_back(e);
    mMode[s] = m; mCmp[s] = c; mMask[s] = k; mLd[s] = ld; mSt[s] = st;
  endtask

  task automatic drive(input bit av, input bit st, input logic [W-1:0] a,
                       input logic [W-1:0] d, input bit fv, input logic [W-1:0] pc,
                       input bit hid, input string tag);
    exp_t e;
    @(negedge clk);
    cfgWrEn = 0;
    accValid = av; accIsStore = st; accAddr = a; accData = d;
    fetchValid = fv; fetchPc = pc; hiddenMode = hid;
    e.req = 0;
    for (int i = N - 1; i >= 0; i--) begin
      if (refHit(i, av, st, a, d, fv, pc, hid)) begin
        e.req = 1;
        heldSlot = 2'(i);
      end
    end
    e.slot = heldSlot; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(0, 0, '0, '0, 0, '0, 0, tag);
  endtask

  // Monitor: compares each result one step after its posedge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (trapReq !== e.req || trapSlot !== e.slot) begin
          errors++;
          $display("FAIL %s: trapReq=%0b trapSlot=%0d expected trapReq=%0b trapSlot=%0d",
                   e.tag, trapReq, trapSlot, e.req, e.slot);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mMode[i] = 0; mCmp[i] = 0; mMask[i] = 0; mLd[i] = 0; mSt[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset values while reset is held
    checks++;
    if (trapReq !== 1'b0 || trapSlot !== 2'd0) begin
      errors++;
      $display("FAIL R1: trapReq=%0b trapSlot=%0d expected 0/0", trapReq, trapSlot);
    end
    rstN = 1;

    // R1: nothing configured, nothing traps
    drive(1, 0, 32'h0000_1000, 32'h0, 1, 32'h0, 0, "R1");
    drive(1, 1, 32'h0, 32'h0, 1, 32'h8000_0000, 0, "R1");

    // R10 / R2: address slot, effective next cycle
    cfg(0, 2'd1, 32'h0000_1000, 32'hFFFF_FFFF, 1, 1);
    drive(1, 0, 32'h0000_1000, 32'h55, 0, '0, 0, "R2");
    drive(1, 1, 32'h0000_1000, 32'h66, 0, '0, 0, "R2");
    drive(1, 0, 32'h0000_1004, 32'h77, 0, '0, 0, "R2");
    idle("R9");

    // R4 / R3: value slot, load only
    cfg(1, 2'd2, 32'h0000_CAFE, 32'hFFFF_FFFF, 1, 0);
    drive(1, 1, 32'h2000, 32'h0000_CAFE, 0, '0, 0, "R4");
    drive(1, 0, 32'h2000, 32'h0000_CAFE, 0, '0, 0, "R3");
    drive(0, 0, 32'h2000, 32'h0000_CAFE, 0, '0, 0, "R4");
    // R3: value slot, store only
    cfg(2, 2'd2, 32'hDEAD_BEEF, 32'hFFFF_FFFF, 0, 1);
    drive(1, 1, 32'h3000, 32'hDEAD_BEEF, 0, '0, 0, "R3");
    drive(1, 0, 32'h3000, 32'hDEAD_BEEF, 0, '0, 0, "R4");

    // R5 / R6: fetch slot with masked low half
    cfg(3, 2'd3, 32'h8000_0000, 32'hFFFF_0000, 0, 0);
    drive(0, 0, '0, '0, 1, 32'h8000_1234, 0, "R6");
    drive(0, 0, '0, '0, 1, 32'h8001_0000, 0, "R6");
    drive(1, 0, 32'h8000_1234, 32'h8000_1234, 0, '0, 0, "R5");
    drive(0, 0, '0, '0, 1, 32'h0000_1000, 0, "R5");

    // R7: overlapping slots
    cfg(2, 2'd1, 32'h0, 32'h0, 1, 1);
    drive(1, 0, 32'h0000_1000, 32'h0, 0, '0, 0, "R7");
    drive(1, 1, 32'h0000_2000, 32'h0, 0, '0, 0, "R7");
    drive(1, 0, 32'h0000_0005, 32'h0000_CAFE, 1, 32'h8000_0000, 0, "R7");
    drive(0, 0, '0, '0, 1, 32'h8000_0010, 0, "R7");

    // R8: hidden mode suppresses, then releases
    drive(1, 0, 32'h0000_1000, 32'h0, 1, 32'h8000_0000, 1, "R8");
    drive(1, 0, 32'h0000_1000, 32'h0, 0, '0, 1, "R8");
    drive(1, 0, 32'h0000_2000, 32'h0, 0, '0, 0, "R8");

    // R9: back-to-back matches, then hold the slot
    drive(1, 0, 32'h0000_1000, 32'h0, 0, '0, 0, "R9");
    drive(0, 0, '0, '0, 1, 32'h8000_4444, 0, "R9");
    idle("R9");
    idle("R9");

    // R10: rewriting a slot to off stops it, others unchanged
    cfg(2, 2'd0, 32'h0, 32'h0, 1, 1);
    drive(1, 0, 32'h0000_2000, 32'h0, 0, '0, 0, "R10");
    drive(1, 1, 32'h0000_1000, 32'h0, 0, '0, 0, "R10");
    idle("R10");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule